// File: doc/BRIEF.md
# Auxiliary Memory DMA Engine

This block copies data between main memory and a secondary (auxiliary) memory in either direction. Software loads a 32-bit main-memory address, a 32-bit auxiliary address and a 32-bit count word through a 16-bit register port. The top bit of the count word selects the direction. Writing the low half of the count word launches the transfer.

Data moves in 8-byte beats over two simple request ports. Each port has a request strobe, a write flag, a 26-bit address and 64-bit data, and read data returns one cycle after a read request.

The busy flag and the completion interrupt follow a timer that is loaded from the byte count. They do not follow the data movement. The timer allows 246 cycles for every 32-byte block, which is always longer than the copy itself. The range check on the auxiliary address is made once, at launch. For it, two addressing details apply:
- The auxiliary side may sit above the installed memory size, and such transfers are handled specially.
- A mirroring memory-map mode copies low auxiliary writes into a second bank.

Top module: `aux_dma`

## Requirements
- R1: A write to select 5 (count low half) while idle launches a transfer. Bits [4:0] of the written value are stored as zero, so a write of 0x005F moves 64 bytes.
- R2: `busy` rises in the cycle after the launch and stays high for D cycles, where D = (count[30:0]/32)*246, or for 1 cycle when D is 0. `irq` is high for exactly one cycle: the first cycle in which `busy` is low again.
- R3: Count bit 31 set moves data from auxiliary memory to main memory. Bit 31 clear moves data from main memory to auxiliary memory.
- R4: At launch both address registers are cut to their low 26 bits. Bits [31:26] read back as zero.
- R5: Each beat moves 8 bytes, adds 8 to both addresses and subtracts 8 from count[30:0]. Beats continue until the count is 0, and no further data moves after that.
- R6: In the auxiliary-to-main direction, when the launch auxiliary address is not below AUX_SIZE, the auxiliary port is never requested and zeros are written to main memory.
- R7: In the main-to-auxiliary direction, when the launch auxiliary address is not below AUX_SIZE, neither port is requested. In the cycle after launch, both addresses have already grown by the full count and count[30:0] reads 0.
- R8: When info register bits [3:0] equal 4, a main-to-auxiliary beat whose auxiliary address is below 0x400000 also writes the same data at that address plus 0x400000. With any other mode value, no second write is made.
- R9: Selects 0/1 (main address high/low), 2/3 (auxiliary address high/low), 4 (count high, direction in bit 15) and 6 (info) are plain 16-bit read/write registers. Select 5 reads the count low half.
- R10: A write to select 5 while `busy` is high is ignored. Timing, data and registers continue as for the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data for cfg_sel (combinational) |
| busy | output | 1 | Transfer in progress |
| irq | output | 1 | One-cycle completion pulse |
| mm_req | output | 1 | Main memory request |
| mm_we | output | 1 | Main memory write flag |
| mm_addr | output | 26 | Main memory byte address |
| mm_wdata | output | 64 | Main memory write data |
| mm_rdata | input | 64 | Main memory read data, one cycle after a read request |
| ax_req | output | 1 | Auxiliary memory request |
| ax_we | output | 1 | Auxiliary memory write flag |
| ax_addr | output | 26 | Auxiliary memory byte address |
| ax_wdata | output | 64 | Auxiliary memory write data |
| ax_rdata | input | 64 | Auxiliary memory read data, one cycle after a read request |

## Verification
The copy is exercised in both directions and at block counts of zero, one and two. Garbage in the count's low five bits and in the address top bits shows whether the launch cleans both before use. The duration of `busy` tells apart a timer built from the count from one that tracks the beats. One extra main-memory entry past the end shows whether the engine overruns.

Auxiliary addresses above the installed size are driven in both directions, which separates zero-fill from write-drop. The same low address is used under mode 4 and mode 3 to expose a missing or a spurious mirror copy. A second launch during a transfer must leave timing and data unchanged.

// File: rtl/aux_dma.sv
module aux_dma #(
  parameter int          AW          = 26,
  parameter int          DW          = 64,
  parameter logic [31:0] AUX_SIZE    = 32'h0100_0000,
  parameter int          CYC_PER_BLK = 246,
  parameter logic [31:0] MIRROR_OFS  = 32'h0040_0000,
  parameter logic [3:0]  MIRROR_MODE = 4'd4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [15:0]   cfg_wdata,
  output logic [15:0]   cfg_rdata,
  output logic          busy,
  output logic          irq,
  output logic          mm_req,
  output logic          mm_we,
  output logic [AW-1:0] mm_addr,
  output logic [DW-1:0] mm_wdata,
  input  logic [DW-1:0] mm_rdata,
  output logic          ax_req,
  output logic          ax_we,
  output logic [AW-1:0] ax_addr,
  output logic [DW-1:0] ax_wdata,
  input  logic [DW-1:0] ax_rdata
);
  localparam int          BEAT      = DW / 8;
  localparam int          BLK_SHIFT = 5;
  localparam int          TW        = 40;
  localparam logic [31:0] ADDR_MASK = 32'((64'd1 << AW) - 64'd1);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_MIR} st_t;

  st_t           st;
  logic [31:0]   ma, xa, cw;
  logic [15:0]   info;
  logic [TW-1:0] tmr;
  logic          busy_q, irq_q, oor_q;
  logic [DW-1:0] hold;

  wire start_req = cfg_we && (cfg_sel == 3'd5);
  wire start     = start_req && !busy_q;

  wire [31:0]   cw_new = {cw[31:16], cfg_wdata & 16'hFFE0};
  wire [31:0]   ma_m   = ma & ADDR_MASK;
  wire [31:0]   xa_m   = xa & ADDR_MASK;
  wire          oor_new = xa_m >= AUX_SIZE;
  wire [TW-1:0] delay  = TW'(cw_new[30:BLK_SHIFT]) * TW'(CYC_PER_BLK);

  wire dir    = cw[31];
  wire mirror = !dir && (info[3:0] == MIRROR_MODE) && (xa < MIRROR_OFS);
  wire last   = cw[30:0] == 31'(BEAT);
  wire adv    = (st == S_WR && !mirror) || st == S_MIR;

  wire [AW-1:0] xa_mir = xa[AW-1:0] + MIRROR_OFS[AW-1:0];

  assign busy = busy_q;
  assign irq  = irq_q;

  assign mm_req   = (st == S_RD && !dir) || (st == S_WR && dir);
  assign mm_we    = st == S_WR;
  assign mm_addr  = ma[AW-1:0];
  assign mm_wdata = oor_q ? '0 : ax_rdata;

  assign ax_req   = (st == S_RD && dir && !oor_q) || (st == S_WR && !dir) || st == S_MIR;
  assign ax_we    = st != S_RD;
  assign ax_addr  = (st == S_MIR) ? xa_mir : xa[AW-1:0];
  assign ax_wdata = (st == S_MIR) ? hold : mm_rdata;

  always_comb begin
    case (cfg_sel)
      3'd0:    cfg_rdata = ma[31:16];
      3'd1:    cfg_rdata = ma[15:0];
      3'd2:    cfg_rdata = xa[31:16];
      3'd3:    cfg_rdata = xa[15:0];
      3'd4:    cfg_rdata = cw[31:16];
      3'd5:    cfg_rdata = cw[15:0];
      3'd6:    cfg_rdata = info;
      default: cfg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ma     <= '0;
      xa     <= '0;
      cw     <= '0;
      info   <= '0;
      tmr    <= '0;
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
      oor_q  <= 1'b0;
      hold   <= '0;
    end else begin
      irq_q <= 1'b0;
      if (cfg_we) begin
        case (cfg_sel)
          3'd0: ma[31:16] <= cfg_wdata;
          3'd1: ma[15:0]  <= cfg_wdata;
          3'd2: xa[31:16] <= cfg_wdata;
          3'd3: xa[15:0]  <= cfg_wdata;
          3'd4: cw[31:16] <= cfg_wdata;
          3'd6: info      <= cfg_wdata;
          default: ;
        endcase
      end
      if (start) begin
        busy_q <= 1'b1;
        tmr    <= delay;
        oor_q  <= oor_new;
        ma     <= ma_m;
        xa     <= xa_m;
        cw     <= cw_new;
        if (cw_new[30:0] == '0) begin
          st <= S_IDLE;
        end else if (!cw_new[31] && oor_new) begin
          ma <= ma_m + {1'b0, cw_new[30:0]};
          xa <= xa_m + {1'b0, cw_new[30:0]};
          cw <= {cw_new[31], 31'd0};
          st <= S_IDLE;
        end else begin
          st <= S_RD;
        end
      end else begin
        if (busy_q) begin
          if (tmr <= TW'(1)) begin
            busy_q <= 1'b0;
            irq_q  <= 1'b1;
          end else begin
            tmr <= tmr - TW'(1);
          end
        end
        case (st)
          S_RD: st <= S_WR;
          S_WR: begin
            hold <= mm_rdata;
            if (mirror) st <= S_MIR;
          end
          default: ;
        endcase
        if (adv) begin
          ma       <= ma + 32'(BEAT);
          xa       <= xa + 32'(BEAT);
          cw[30:0] <= cw[30:0] - 31'(BEAT);
          st       <= last ? S_IDLE : S_RD;
        end
      end
    end
  end

  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q);

  p_irq_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (!busy_q && $past(busy_q)));

  p_dir_ports_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mm_req && mm_we) |-> dir) and ((ax_req && ax_we) |-> !dir));

  p_addr_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (ma[31:AW] == '0 && xa[31:AW] == '0));

  p_beat_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !cfg_we) |=> (cw[30:0] == $past(cw[30:0]) - 31'(BEAT)));

  p_oor_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ax_req |-> !oor_q);

  p_mirror_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_MIR) |-> $past(ax_req && ax_we));

  p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_req) |=> $stable(cw[31]));
endmodule

// File: tb/sim_aux_dma.sv
`timescale 1ns/1ps
module sim_aux_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        busy, irq;
  logic        mm_req, mm_we, ax_req, ax_we;
  logic [25:0] mm_addr, ax_addr;
  logic [63:0] mm_wdata, ax_wdata;
  logic [63:0] mm_rdata = '0, ax_rdata = '0;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, ax_acc = 0, mm_acc = 0;
  bit done = 1'b0;
  logic [63:0] mmem [int];
  logic [63:0] amem [int];

  always #2 clk = ~clk;

  aux_dma u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy), .irq(irq),
    .mm_req(mm_req), .mm_we(mm_we), .mm_addr(mm_addr), .mm_wdata(mm_wdata),
    .mm_rdata(mm_rdata), .ax_req(ax_req), .ax_we(ax_we), .ax_addr(ax_addr),
    .ax_wdata(ax_wdata), .ax_rdata(ax_rdata)
  );

  always @(posedge clk) begin
    cyc++;
    if (mm_req) begin
      mm_acc++;
      if (mm_we) mmem[int'(mm_addr >> 3)] = mm_wdata;
      else mm_rdata <= mmem.exists(int'(mm_addr >> 3)) ? mmem[int'(mm_addr >> 3)] : '0;
    end
    if (ax_req) begin
      ax_acc++;
      if (ax_we) amem[int'(ax_addr >> 3)] = ax_wdata;
      else ax_rdata <= amem.exists(int'(ax_addr >> 3)) ? amem[int'(ax_addr >> 3)] : '0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [15:0] d);
    cfg_sel = s;
    #0.5;
    d = cfg_rdata;
  endtask

  task automatic prog(input logic [31:0] ma, input logic [31:0] xa,
                      input logic [15:0] cwhi, input logic [15:0] inf);
    wr(3'd0, ma[31:16]); wr(3'd1, ma[15:0]);
    wr(3'd2, xa[31:16]); wr(3'd3, xa[15:0]);
    wr(3'd4, cwhi);      wr(3'd6, inf);
  endtask

  task automatic wait_done(input string req, input int exp_cyc);
    int t0 = cyc;
    check(busy === 1'b1, req, "busy after launch", longint'(busy), 1);
    while (busy === 1'b1 && cyc - t0 < 5000) @(negedge clk);
    check(cyc - t0 == exp_cyc, req, "busy duration", cyc - t0, exp_cyc);
    check(irq === 1'b1, req, "irq on first idle cycle", longint'(irq), 1);
    @(negedge clk);
    check(irq === 1'b0, req, "irq single pulse", longint'(irq), 0);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check(busy === 1'b0 && irq === 1'b0, "R2", "reset busy/irq", {busy, irq}, 0);
    for (int s = 0; s < 7; s++) begin
      rd(3'(s), v);
      check(v === 16'h0, "R9", "reset register", v, 0);
    end
  endtask

  task automatic t_regs;
    logic [15:0] v;
    for (int s = 0; s < 7; s++) if (s != 5) wr(3'(s), 16'h1230 + 16'(s));
    for (int s = 0; s < 7; s++) begin
      if (s == 5) continue;
      rd(3'(s), v);
      check(v === 16'h1230 + 16'(s), "R9", "register readback", v, 16'h1230 + 16'(s));
    end
  endtask

  task automatic t_main_to_aux;
    logic [15:0] v;
    for (int i = 0; i < 9; i++) mmem[(32'h140 >> 3) + i] = 64'hA5A5_0000_0000_0000 + 64'(i);
    prog(32'hFC00_0140, 32'h0000_0800, 16'h0000, 16'h0000);
    wr(3'd5, 16'h005F);
    wait_done("R1", 492);
    for (int i = 0; i < 8; i++)
      check(amem.exists((32'h800 >> 3) + i) && amem[(32'h800 >> 3) + i] === 64'hA5A5_0000_0000_0000 + 64'(i),
            "R3", "main to aux data", amem.exists((32'h800 >> 3) + i) ? amem[(32'h800 >> 3) + i] : 0,
            64'hA5A5_0000_0000_0000 + 64'(i));
    check(!amem.exists((32'h800 >> 3) + 8), "R5", "no overrun beat", 1, 0);
    rd(3'd0, v); check(v === 16'h0000, "R4", "main addr high masked", v, 0);
    rd(3'd1, v); check(v === 16'h0180, "R5", "main addr advanced", v, 16'h0180);
    rd(3'd3, v); check(v === 16'h0840, "R5", "aux addr advanced", v, 16'h0840);
    rd(3'd5, v); check(v === 16'h0000, "R5", "count drained", v, 0);
  endtask

  task automatic t_aux_to_main;
    logic [15:0] v;
    for (int i = 0; i < 4; i++) amem[(32'h1000 >> 3) + i] = 64'h5A00_0000_0000_1000 + 64'(i);
    prog(32'h0000_2000, 32'h0000_1000, 16'h8000, 16'h0000);
    wr(3'd5, 16'h0020);
    wait_done("R2", 246);
    for (int i = 0; i < 4; i++)
      check(mmem.exists((32'h2000 >> 3) + i) && mmem[(32'h2000 >> 3) + i] === 64'h5A00_0000_0000_1000 + 64'(i),
            "R3", "aux to main data", mmem.exists((32'h2000 >> 3) + i) ? mmem[(32'h2000 >> 3) + i] : 0,
            64'h5A00_0000_0000_1000 + 64'(i));
    rd(3'd4, v); check(v === 16'h8000, "R3", "direction bit kept", v, 16'h8000);
  endtask

  task automatic t_aux_oor_read;
    int a0;
    for (int i = 0; i < 4; i++) mmem[(32'h3000 >> 3) + i] = 64'hDEAD_BEEF_0000_0000 + 64'(i);
    prog(32'h0000_3000, 32'h0200_0000, 16'h8000, 16'h0000);
    a0 = ax_acc;
    wr(3'd5, 16'h0020);
    wait_done("R6", 246);
    for (int i = 0; i < 4; i++)
      check(mmem[(32'h3000 >> 3) + i] === 64'h0, "R6", "zero fill", mmem[(32'h3000 >> 3) + i], 0);
    check(ax_acc == a0, "R6", "aux port untouched", ax_acc - a0, 0);
  endtask

  task automatic t_aux_oor_write;
    logic [15:0] v;
    int a0, m0;
    prog(32'h0000_4000, 32'h0300_0000, 16'h0000, 16'h0000);
    a0 = ax_acc; m0 = mm_acc;
    wr(3'd5, 16'h0040);
    rd(3'd5, v); check(v === 16'h0000, "R7", "count cleared at once", v, 0);
    rd(3'd1, v); check(v === 16'h4040, "R7", "main addr jumped", v, 16'h4040);
    rd(3'd2, v); check(v === 16'h0300, "R7", "aux addr high", v, 16'h0300);
    rd(3'd3, v); check(v === 16'h0040, "R7", "aux addr jumped", v, 16'h0040);
    wait_done("R7", 492);
    check(ax_acc == a0 && mm_acc == m0, "R7", "no port activity", (ax_acc - a0) + (mm_acc - m0), 0);
  endtask

  task automatic t_mirror;
    for (int i = 0; i < 4; i++) mmem[(32'h5000 >> 3) + i] = 64'h0123_0000_0000_0000 + 64'(i);
    prog(32'h0000_5000, 32'h0000_0100, 16'h0000, 16'h0004);
    wr(3'd5, 16'h0020);
    wait_done("R8", 246);
    for (int i = 0; i < 4; i++) begin
      check(amem.exists((32'h100 >> 3) + i) && amem[(32'h100 >> 3) + i] === 64'h0123_0000_0000_0000 + 64'(i),
            "R8", "primary copy", amem.exists((32'h100 >> 3) + i) ? amem[(32'h100 >> 3) + i] : 0,
            64'h0123_0000_0000_0000 + 64'(i));
      check(amem.exists((32'h400100 >> 3) + i) && amem[(32'h400100 >> 3) + i] === 64'h0123_0000_0000_0000 + 64'(i),
            "R8", "mirror copy", amem.exists((32'h400100 >> 3) + i) ? amem[(32'h400100 >> 3) + i] : 0,
            64'h0123_0000_0000_0000 + 64'(i));
    end
    prog(32'h0000_5000, 32'h0000_0200, 16'h0000, 16'h0003);
    wr(3'd5, 16'h0020);
    wait_done("R8", 246);
    check(amem.exists(32'h200 >> 3), "R8", "mode 3 primary copy", 0, 1);
    check(!amem.exists(32'h400200 >> 3), "R8", "mode 3 no mirror", 1, 0);
  endtask

  task automatic t_busy_restart;
    logic [15:0] v;
    int t0;
    for (int i = 0; i < 5; i++) mmem[(32'h6000 >> 3) + i] = 64'h7700_0000_0000_0000 + 64'(i);
    prog(32'h0000_6000, 32'h0000_3000, 16'h0000, 16'h0000);
    wr(3'd5, 16'h0020);
    t0 = cyc;
    repeat (10) @(negedge clk);
    wr(3'd5, 16'h0100);
    while (busy === 1'b1 && cyc - t0 < 5000) @(negedge clk);
    check(cyc - t0 == 246, "R10", "busy duration unchanged", cyc - t0, 246);
    check(irq === 1'b1, "R10", "single completion", longint'(irq), 1);
    check(!amem.exists((32'h3000 >> 3) + 4), "R10", "no extra beat", 1, 0);
    rd(3'd5, v); check(v === 16'h0000, "R10", "count not reloaded", v, 0);
    rd(3'd3, v); check(v === 16'h3020, "R10", "aux addr of first run", v, 16'h3020);
  endtask

  task automatic t_zero_count;
    int m0;
    prog(32'h0000_7000, 32'h0000_7000, 16'h0000, 16'h0000);
    m0 = mm_acc;
    wr(3'd5, 16'h001F);
    wait_done("R2", 1);
    check(mm_acc == m0, "R5", "zero count moves nothing", mm_acc - m0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_main_to_aux();
    t_aux_to_main();
    t_aux_oor_read();
    t_aux_oor_write();
    t_mirror();
    t_busy_restart();
    t_zero_count();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(100000 * 4);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule